// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry and Return

This block is the control unit of a small accumulator machine. It steps the machine through the instruction cycle. Each instruction starts with a fetch phase, which is the same for every opcode. A decode step and an execute phase follow, and the execute phase depends on the opcode held in the instruction register. A single memory port carries every access: instruction words, operands, stack pushes and stack pops. Every access waits on a ready handshake from memory.

Interrupt requests are examined at one point only: after an instruction's execute phase has finished. A request is taken when at least one source is pending and the interrupt-enable flag is set. Taking it pulses an acknowledge that names the chosen source, and clears the enable flag. It then pushes the return address and the flag word onto a downward-growing stack, and loads the program counter with that source's vector. A return-from-interrupt opcode pops the flag word and then the return address, and sets the enable flag again. A stop opcode parks the machine for good.

Top module: `cpuseq_top`

## Requirements
- R1: A synchronous reset clears the program counter and the enable flag, and sets the stack pointer to STACK_TOP. While reset is held there is no memory access, no acknowledge and no halt indication. The first access after release is an instruction read at address 0, asserted in the first cycle after reset is released.
- R2: Every instruction begins with a read of the word at the program counter, and the counter then advances by one. With no wait cycles, a one-cycle opcode takes 7 cycles from its instruction read to the next instruction read.
- R3: A read or write request stays asserted with a stable address until `mem_ready` is sampled high. Each cycle with ready low adds exactly one cycle to the instruction.
- R4: An instruction word carries the opcode in bits [15:12] and an address in bits [11:0]. The opcodes are:
  - 0: no-op
  - 1: load the accumulator from the addressed word
  - 2: store the accumulator to the addressed word
  - 3: add the addressed word to the accumulator
  - 4: jump to the address
  - 5: enable interrupts
  - 6: disable interrupts
  - 7: return from interrupt
  - F: stop

  Any other opcode acts as a no-op. The add sets the zero flag (bit 0 of the flag word) and the carry-out flag (bit 1). Loads leave both flags unchanged.
- R5: Requests are examined only after an instruction's execute phase. A pending request while interrupts are disabled does not stop the next instruction read.
- R6: Taking an interrupt works as follows:
  - it pulses `irq_ack` for one cycle, with `irq_id` naming the lowest-numbered pending source;
  - it writes the return address to SP-1 and then the flag word to SP-2, decrementing SP before each write;
  - the next instruction read is at VEC_BASE + id*VEC_STRIDE.
- R7: Entering a handler clears the enable flag. A request that arrives during the handler stays pending and is taken only after interrupts are enabled again.
- R8: Return-from-interrupt first reads the flag word at SP and then the return address at SP+1, incrementing SP after each read. It restores both flags, sets the enable flag, and resumes at the popped address.
- R9: The stop opcode raises `halted` permanently. After that there is no memory access and no acknowledge, even with requests pending.
- R10: The enable and disable opcodes take effect at the check point of their own instruction. The enable flag rises only through the enable opcode or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, taken when ready is high |
| mem_ready | input | 1 | Completes the current request this cycle |
| irq_req | input | NSRC | Level interrupt requests, one per source |
| irq_ack | output | 1 | One-cycle acknowledge of a taken request |
| irq_id | output | SW | Source being acknowledged |
| halted | output | 1 | Machine stopped |

## Verification
The bench builds the block with 16-bit words, 12-bit addresses and four request sources. The stack top is set to 0xE00, and the vector base is 0x100 with a stride of 0x10, so handlers, stack frames and data all sit in separate, recognisable regions. Four sources are enough for one request to arrive inside a handler while two others are pending at once. That makes the lowest-index choice, back-to-back entries straight after a return, and a nested push of restored flags all visible on the memory port.

// File: rtl/cpuseq_pkg.sv
package cpuseq_pkg;

    typedef enum logic [4:0] {
        ST_F_MAR,
        ST_F_MEM,
        ST_F_INC,
        ST_F_IR,
        ST_DECODE,
        ST_EX_SIMPLE,
        ST_EX_MAR,
        ST_EX_RD,
        ST_EX_ALU,
        ST_EX_WR,
        ST_RTI_PSW,
        ST_RTI_PC,
        ST_ICHECK,
        ST_INT_ACK,
        ST_PUSH_PC,
        ST_PUSH_PSW,
        ST_VECTOR,
        ST_HALT
    } seq_state_e;

    localparam logic [3:0] OP_NOP    = 4'h0;
    localparam logic [3:0] OP_LOAD   = 4'h1;
    localparam logic [3:0] OP_STORE  = 4'h2;
    localparam logic [3:0] OP_ADD    = 4'h3;
    localparam logic [3:0] OP_JUMP   = 4'h4;
    localparam logic [3:0] OP_INTON  = 4'h5;
    localparam logic [3:0] OP_INTOFF = 4'h6;
    localparam logic [3:0] OP_RETI   = 4'h7;
    localparam logic [3:0] OP_STOP   = 4'hF;

    localparam int FLAG_Z = 0;
    localparam int FLAG_C = 1;

endpackage

// File: rtl/cpuseq_adder.sv
module cpuseq_adder #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic          zero
);
    logic [DW:0] full;

    assign full  = {1'b0, a} + {1'b0, b};
    assign sum   = full[DW-1:0];
    assign carry = full[DW];
    assign zero  = (full[DW-1:0] == '0);
endmodule

// File: rtl/cpuseq_irq_pick.sv
module cpuseq_irq_pick #(
    parameter int NSRC = 4,
    parameter int SW   = 2
) (
    input  logic [NSRC-1:0] req,
    output logic            any,
    output logic [SW-1:0]   id
);
    assign any = |req;

    // lowest index wins
    always_comb begin
        id = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) id = SW'(i);
        end
    end

    always_comb begin
        p_pick_valid_r6: assert (!any || req[id]);
    end
endmodule

// File: rtl/cpuseq_top.sv
module cpuseq_top
    import cpuseq_pkg::*;
#(
    parameter int          DW         = 16,
    parameter int          AW         = 12,
    parameter int          NSRC       = 4,
    parameter int unsigned STACK_TOP  = 'hF00,
    parameter int unsigned VEC_BASE   = 'h100,
    parameter int unsigned VEC_STRIDE = 'h10,
    localparam int         SW         = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ready,
    input  logic [NSRC-1:0] irq_req,
    output logic            irq_ack,
    output logic [SW-1:0]   irq_id,
    output logic            halted
);
    localparam logic [AW-1:0] SP_INIT  = AW'(STACK_TOP);
    localparam logic [AW-1:0] VEC_B    = AW'(VEC_BASE);
    localparam logic [AW-1:0] VEC_S    = AW'(VEC_STRIDE);
    localparam int            OPC_MSB  = DW - 1;

    typedef struct packed {
        seq_state_e      st;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   mar;
        logic [AW-1:0]   sp;
        logic [DW-1:0]   mbr;
        logic [DW-1:0]   ir;
        logic [DW-1:0]   acc;
        logic            z;
        logic            c;
        logic            ie;
        logic [SW-1:0]   src;
    } seq_regs_t;

    seq_regs_t q_q, d_d;

    logic [3:0]    opcode;
    logic [AW-1:0] operand;
    logic          req_any;
    logic [SW-1:0] req_id;
    logic [DW-1:0] add_sum;
    logic          add_c, add_z;
    logic [AW-1:0] sp_dn;
    logic [AW-1:0] sp_up;
    logic [AW-1:0] vec_addr;

    assign opcode   = q_q.ir[OPC_MSB -: 4];
    assign operand  = q_q.ir[AW-1:0];
    assign sp_dn    = q_q.sp - AW'(1);
    assign sp_up    = q_q.sp + AW'(1);
    assign vec_addr = VEC_B + ({{(AW-SW){1'b0}}, q_q.src} * VEC_S);

    cpuseq_irq_pick #(.NSRC(NSRC), .SW(SW)) i_pick (
        .req (irq_req),
        .any (req_any),
        .id  (req_id)
    );

    cpuseq_adder #(.DW(DW)) i_adder (
        .a     (q_q.acc),
        .b     (q_q.mbr),
        .sum   (add_sum),
        .carry (add_c),
        .zero  (add_z)
    );

    always_comb begin
        d_d       = q_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = q_q.mar;
        mem_wdata = q_q.acc;
        irq_ack   = 1'b0;
        irq_id    = q_q.src;
        halted    = 1'b0;
        unique case (q_q.st)
            ST_F_MAR: begin
                d_d.mar = q_q.pc;
                d_d.st  = ST_F_MEM;
            end
            ST_F_MEM: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    d_d.mbr = mem_rdata;
                    d_d.st  = ST_F_INC;
                end
            end
            ST_F_INC: begin
                d_d.pc = q_q.pc + AW'(1);
                d_d.st = ST_F_IR;
            end
            ST_F_IR: begin
                d_d.ir = q_q.mbr;
                d_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                case (opcode)
                    OP_LOAD, OP_STORE, OP_ADD: d_d.st = ST_EX_MAR;
                    OP_RETI:                   d_d.st = ST_RTI_PSW;
                    OP_STOP:                   d_d.st = ST_HALT;
                    default:                   d_d.st = ST_EX_SIMPLE;
                endcase
            end
            ST_EX_SIMPLE: begin
                case (opcode)
                    OP_JUMP:   d_d.pc = operand;
                    OP_INTON:  d_d.ie = 1'b1;
                    OP_INTOFF: d_d.ie = 1'b0;
                    default:   d_d.pc = q_q.pc;
                endcase
                d_d.st = ST_ICHECK;
            end
            ST_EX_MAR: begin
                d_d.mar = operand;
                d_d.st  = (opcode == OP_STORE) ? ST_EX_WR : ST_EX_RD;
            end
            ST_EX_RD: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    d_d.mbr = mem_rdata;
                    d_d.st  = ST_EX_ALU;
                end
            end
            ST_EX_ALU: begin
                if (opcode == OP_ADD) begin
                    d_d.acc = add_sum;
                    d_d.z   = add_z;
                    d_d.c   = add_c;
                end else begin
                    d_d.acc = q_q.mbr;
                end
                d_d.st = ST_ICHECK;
            end
            ST_EX_WR: begin
                mem_wr = 1'b1;
                if (mem_ready) d_d.st = ST_ICHECK;
            end
            ST_RTI_PSW: begin
                mem_rd   = 1'b1;
                mem_addr = q_q.sp;
                if (mem_ready) begin
                    d_d.z  = mem_rdata[FLAG_Z];
                    d_d.c  = mem_rdata[FLAG_C];
                    d_d.sp = sp_up;
                    d_d.st = ST_RTI_PC;
                end
            end
            ST_RTI_PC: begin
                mem_rd   = 1'b1;
                mem_addr = q_q.sp;
                if (mem_ready) begin
                    d_d.pc = mem_rdata[AW-1:0];
                    d_d.sp = sp_up;
                    d_d.ie = 1'b1;
                    d_d.st = ST_ICHECK;
                end
            end
            ST_ICHECK: begin
                if (req_any && q_q.ie) begin
                    d_d.src = req_id;
                    d_d.st  = ST_INT_ACK;
                end else begin
                    d_d.st  = ST_F_MAR;
                end
            end
            ST_INT_ACK: begin
                irq_ack = 1'b1;
                d_d.ie  = 1'b0;
                d_d.st  = ST_PUSH_PC;
            end
            ST_PUSH_PC: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_dn;
                mem_wdata = {{(DW-AW){1'b0}}, q_q.pc};
                if (mem_ready) begin
                    d_d.sp = sp_dn;
                    d_d.st = ST_PUSH_PSW;
                end
            end
            ST_PUSH_PSW: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_dn;
                mem_wdata = {{(DW-2){1'b0}}, q_q.c, q_q.z};
                if (mem_ready) begin
                    d_d.sp = sp_dn;
                    d_d.st = ST_VECTOR;
                end
            end
            ST_VECTOR: begin
                d_d.pc = vec_addr;
                d_d.st = ST_F_MAR;
            end
            ST_HALT: begin
                halted = 1'b1;
            end
            default: d_d.st = ST_F_MAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q    <= '0;
            q_q.st <= ST_F_MAR;
            q_q.sp <= SP_INIT;
        end else begin
            q_q    <= d_d;
        end
    end

    p_one_access_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_hold_request_r3: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && !mem_ready) |=> ((mem_rd || mem_wr) && $stable(mem_addr)));

    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    p_ack_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> q_q.ie);

    p_entry_disables_r7: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !q_q.ie);

    p_enable_source_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(q_q.ie) |-> ($past(q_q.st) == ST_EX_SIMPLE || $past(q_q.st) == ST_RTI_PC));

    p_halt_final_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_rd && !mem_wr && !irq_ack));
endmodule

// File: tb/test_cpuseq_top.sv
`timescale 1ns/1ps
module test_cpuseq_top;
    localparam int DW   = 16;
    localparam int AW   = 12;
    localparam int NSRC = 4;
    localparam int STK  = 'hE00;
    localparam int VB   = 'h100;
    localparam int VS   = 'h10;
    localparam int DEV  = 'hFF0;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            mem_rd, mem_wr;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata = '0;
    logic            mem_ready = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic            irq_ack;
    logic [1:0]      irq_id;
    logic            halted;

    always #10 clk = ~clk;

    cpuseq_top #(.DW(DW), .AW(AW), .NSRC(NSRC), .STACK_TOP(STK),
                 .VEC_BASE(VB), .VEC_STRIDE(VS)) i_cpuseq_top (
        .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .irq_req(irq_req), .irq_ack(irq_ack),
        .irq_id(irq_id), .halted(halted)
    );

    typedef struct {
        int    kind;  // 0 read, 1 write, 2 acknowledge
        int    addr;
        int    data;
        string tag;
    } ev_t;

    ev_t         expq[$];
    logic [15:0] sim_mem[int];
    logic [15:0] ref_mem[int];
    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int rmem(input int a);
        return ref_mem.exists(a) ? int'(ref_mem[a]) : 0;
    endfunction

    function automatic logic [15:0] smem(input int a);
        return sim_mem.exists(a) ? sim_mem[a] : 16'h0;
    endfunction

    task automatic put(input int a, input int w);
        sim_mem[a] = w[15:0];
        ref_mem[a] = w[15:0];
    endtask

    task automatic add_ev(input int k, input int a, input int d, input string t);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d; e.tag = t;
        expq.push_back(e);
    endtask

    // instruction-level reference: produces the expected memory-port events
    task automatic build_expect();
        int pc = 0, sp = STK, acc = 0, pend = 0, depth = 0;
        bit z = 0, c = 0, ie = 0, stop = 0;
        string ftag = "R1";
        for (int n = 0; n < 300 && !stop; n++) begin
            int ir, op, a, s, w, id;
            add_ev(0, pc, 0, ftag);
            ftag = "R2";
            ir = rmem(pc);
            pc = (pc + 1) & 'hFFF;
            op = (ir >> 12) & 'hF;
            a  = ir & 'hFFF;
            case (op)
                1: begin add_ev(0, a, 0, "R4"); acc = rmem(a); end
                2: begin
                    add_ev(1, a, acc, "R4");
                    ref_mem[a] = acc[15:0];
                    if (a == DEV) pend = pend | (acc & 'hF);
                end
                3: begin
                    add_ev(0, a, 0, "R4");
                    s = acc + rmem(a);
                    acc = s & 'hFFFF;
                    c = s[16];
                    z = (acc == 0);
                end
                4: pc = a;
                5: begin ie = 1; ftag = "R10"; end
                6: begin ie = 0; ftag = "R10"; end
                7: begin
                    add_ev(0, sp, 0, "R8");
                    w = rmem(sp); z = w[0]; c = w[1];
                    sp = sp + 1;
                    add_ev(0, sp, 0, "R8");
                    pc = rmem(sp) & 'hFFF;
                    sp = sp + 1;
                    ie = 1;
                    depth = depth - 1;
                    ftag = "R8";
                end
                15: stop = 1;
                default: ;
            endcase
            if (!stop && pend != 0) begin
                if (ie) begin
                    id = 0;
                    while (!pend[id]) id++;
                    add_ev(2, 0, id, "R6");
                    pend = pend & ~(1 << id);
                    ie = 0;
                    depth = depth + 1;
                    sp = sp - 1;
                    add_ev(1, sp, pc, "R6");
                    ref_mem[sp] = pc[15:0];
                    sp = sp - 1;
                    add_ev(1, sp, int'(c) * 2 + int'(z), "R6");
                    ref_mem[sp] = 16'(int'(c) * 2 + int'(z));
                    pc = VB + id * VS;
                    ftag = "R6";
                end else begin
                    ftag = (depth > 0) ? "R7" : "R5";
                end
            end
        end
    endtask

    task automatic compare(input int k, input int a, input int d);
        ev_t e;
        int  act, exp;
        if (expq.size() == 0) begin
            chk(0, "R9", "event after expected end", (k << 28) | (a << 16), 0);
        end else begin
            e   = expq.pop_front();
            act = (k << 28) | (a << 16) | ((k != 0) ? (d & 'hFFFF) : 0);
            exp = (e.kind << 28) | (e.addr << 16) | ((e.kind != 0) ? (e.data & 'hFFFF) : 0);
            chk(act == exp, e.tag, "port event kind/addr/data", act, exp);
        end
    endtask

    bit run = 0, waits_on = 0, w1done = 0, after_halt = 0, halt_act = 0, irq_posted = 0;
    bit prev_wait = 0;
    int prev_addr = 0, w1cnt = 0;
    int c_at[3] = '{-1, -1, -1};

    always @(negedge clk) begin
        if (run) begin
            if (prev_wait)
                chk((mem_rd || mem_wr) && int'(mem_addr) == prev_addr, "R3",
                    "request held while waiting", int'(mem_addr), prev_addr);
            if (mem_rd && mem_addr == 1 && !w1done) begin
                if (w1cnt < 2) begin mem_ready = 1'b0; w1cnt++; end
                else begin mem_ready = 1'b1; w1done = 1; end
            end else if (waits_on) begin
                mem_ready = (cyc % 3 != 0);
            end else begin
                mem_ready = 1'b1;
            end
            mem_rdata = smem(int'(mem_addr));
            prev_wait = (mem_rd || mem_wr) && !mem_ready;
            prev_addr = int'(mem_addr);
            if (after_halt && (mem_rd || mem_wr || irq_ack)) halt_act = 1;
            if (after_halt && !irq_posted) begin irq_req[0] = 1'b1; irq_posted = 1; end
            if (mem_ready && (mem_rd || mem_wr)) begin
                compare(mem_wr ? 1 : 0, int'(mem_addr), int'(mem_wdata));
                if (mem_wr) begin
                    sim_mem[int'(mem_addr)] = mem_wdata;
                    if (mem_addr == DEV) irq_req = irq_req | mem_wdata[3:0];
                end else if (mem_addr < 3 && c_at[mem_addr] < 0) begin
                    c_at[mem_addr] = cyc;
                    if (mem_addr == 2) waits_on = 1;
                end
            end
            if (irq_ack) begin
                compare(2, 0, int'(irq_id));
                irq_req[irq_id] = 1'b0;
            end
        end
    end

    int rel;
    initial begin
        put('h000, 'h0000); put('h001, 'h0000); put('h002, 'h0000);
        put('h003, 'h1300); put('h004, 'h3301); put('h005, 'h2302);
        put('h006, 'h1303); put('h007, 'h2FF0); put('h008, 'h5000);
        put('h009, 'h6000); put('h00A, 'h1308); put('h00B, 'h2FF0);
        put('h00C, 'h4020);
        put('h020, 'h5000); put('h021, 'h8000); put('h022, 'hF000);
        put('h100, 'h2307); put('h101, 'h7000);
        put('h110, 'h7000);
        put('h120, 'h1304); put('h121, 'h2FF0); put('h122, 'h1305);
        put('h123, 'h3305); put('h124, 'h2306); put('h125, 'h7000);
        put('h130, 'h7000);
        put('h300, 'h7FFF); put('h301, 'h8001); put('h303, 'h0004);
        put('h304, 'h0003); put('h305, 'h0001); put('h308, 'h0008);
        build_expect();

        repeat (3) @(negedge clk);
        chk(!mem_rd && !mem_wr, "R1", "no access during reset", int'(mem_rd | mem_wr), 0);
        chk(!irq_ack, "R1", "no acknowledge during reset", int'(irq_ack), 0);
        chk(!halted, "R1", "not halted during reset", int'(halted), 0);
        rst = 1'b0;
        rel = cyc;
        run = 1;

        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (halted) break;
        end
        if (!halted) chk(0, "R9", "watchdog: stop state not reached", 0, 1);
        @(negedge clk);
        chk(expq.size() == 0, "R9", "expected events left over", expq.size(), 0);
        chk(c_at[0] == rel + 1, "R1", "first read cycle after release", c_at[0] - rel, 1);
        chk(c_at[1] - c_at[0] == 9, "R3", "two wait cycles lengthen the no-op", c_at[1] - c_at[0], 9);
        chk(c_at[2] - c_at[1] == 7, "R2", "no-op length without waits", c_at[2] - c_at[1], 7);
        chk(sim_mem[STK - 1] == 16'h0021, "R6", "last pushed return address", int'(smem(STK - 1)), 'h21);
        chk(sim_mem['h302] == 16'h0000, "R4", "add wraps to zero", int'(smem('h302)), 0);

        after_halt = 1;
        repeat (40) @(negedge clk);
        chk(halted, "R9", "halted stays high", int'(halted), 1);
        chk(!halt_act, "R9", "no activity after stop with request pending", int'(halt_act), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule